// File: doc/BRIEF.md
# Colour Palette Loader

This block holds a 256-entry colour lookup table of 24-bit RGB values and lets a host fill it through a four-word register window. The host first writes a starting entry number to the index register. It then writes colour bytes to the colour register in groups of three. Each group fills red, then green, then blue of the current entry. After the blue byte the entry number steps forward by one, so a whole table can be loaded with one index write followed by a stream of colour writes.

Only the top byte of each 32-bit bus write is used. The window cannot be read back: bus reads return zero. A separate lookup port gives display logic a synchronous read of any entry, one clock after the entry number is presented.

Top module: `pal_dac_loader`

## Requirements
- R1: After reset, entries 0 to 254 hold 0x000000 and entry 255 holds 0xFFFFFF (red in bits [23:16], green in [15:8], blue in [7:0]). The current index and the colour phase are both 0, so the first colour write after reset goes to the red byte of entry 0.
- R2: The register is picked by bus_addr[3:2]: 0 selects the index register and 1 selects the colour register. bus_addr[1:0] has no effect on the selection.
- R3: A write to the index register loads the current index from bus_wdata[31:24].
- R4: Successive writes to the colour register store bus_wdata[31:24] into the red, green and blue bytes of the current entry, in that order.
- R5: The blue write moves the index up by one, modulo 256, so 255 wraps to 0, and returns the phase to red.
- R6: A write to the index register partway through a colour group puts the phase back to red.
- R7: Writes to words 2 and 3, bus cycles with bus_write=0 and cycles with bus_valid=0 change neither the table, the index nor the phase.
- R8: bus_rdata is zero at all times.
- R9: lkp_rgb shows the entry selected by lkp_idx one clock later. A colour write becomes visible to a lookup issued in the following cycle.
- R10: bus_wdata[23:0] has no effect on any stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus transfer this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address within the window |
| bus_wdata | input | 32 | Write data; only the top byte is used |
| bus_rdata | output | 32 | Read data, always zero |
| lkp_idx | input | 8 | Entry number for a lookup |
| lkp_rgb | output | 24 | Colour of the looked-up entry, one cycle later |

## Verification
The load path is exercised in several ways:
- A plain three-byte group at a mid-table entry.
- Groups that start at entry 255, which show whether the index wraps to 0.
- Groups broken off by a fresh index write, which show whether the phase restarts.
- Streams mixed with writes to the unused words, with reads, and with idle cycles, which show whether only real colour writes advance the sequencer.

Data words carry noise in their low 24 bits, and addresses are used with nonzero low bits, to expose any decode that looks at the wrong bits. A lookup is kept on the entry being written, which checks the one-cycle visibility. After reset the whole table is swept to confirm the black and white reset contents.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam int unsigned NUM_COMP = 3;
endpackage

// File: rtl/pal_decode.sv
module pal_decode #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              idx_wr,
    output logic              col_wr
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              wr;

    always_comb begin
        word   = bus_addr[ADDR_W-1:2];
        wr     = bus_valid && bus_write;
        idx_wr = wr && (word == WORD_W'(0));
        col_wr = wr && (word == WORD_W'(1));
    end
endmodule

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idx_wr,
    input  logic                col_wr,
    input  logic [IDX_W-1:0]    new_idx,
    output logic [IDX_W-1:0]    idx_q,
    output phase_e              phase_q,
    output logic [NUM_COMP-1:0] comp_we
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        phase_e           phase;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        comp_we = '0;
        if (idx_wr) begin
            st_d.idx   = new_idx;
            st_d.phase = PH_RED;
        end else if (col_wr) begin
            unique case (st_q.phase)
                PH_RED: begin
                    comp_we[0] = 1'b1;
                    st_d.phase = PH_GRN;
                end
                PH_GRN: begin
                    comp_we[1] = 1'b1;
                    st_d.phase = PH_BLU;
                end
                default: begin
                    comp_we[2] = 1'b1;
                    st_d.phase = PH_RED;
                    st_d.idx   = st_q.idx + IDX_W'(1);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, phase: PH_RED};
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_q   = st_q.idx;
    assign phase_q = st_q.phase;
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_COMP-1:0]        comp_we,
    input  logic [IDX_W-1:0]           w_idx,
    input  logic [COMP_W-1:0]          w_byte,
    input  logic [IDX_W-1:0]           r_idx,
    output logic [NUM_COMP*COMP_W-1:0] r_rgb
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_plane
        logic [COMP_W-1:0] cell_q [ENTRIES];
        logic [COMP_W-1:0] rd_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    cell_q[i] <= (i == ENTRIES - 1) ? '1 : '0;
                end
                rd_q <= '0;
            end else begin
                rd_q <= cell_q[r_idx];
                if (comp_we[c]) begin
                    cell_q[w_idx] <= w_byte;
                end
            end
        end

        // component 0 (red) lands in the most significant byte
        assign r_rgb[(NUM_COMP-c)*COMP_W-1 -: COMP_W] = rd_q;
    end
endmodule

// File: rtl/pal_dac_loader.sv
module pal_dac_loader
    import pal_pkg::*;
#(
    parameter int unsigned WIN_BYTES = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned COMP_W    = 8,
    localparam int unsigned ADDR_W   = $clog2(WIN_BYTES),
    localparam int unsigned RGB_W    = NUM_COMP * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  lkp_idx,
    output logic [RGB_W-1:0]  lkp_rgb
);
    logic                idx_wr;
    logic                col_wr;
    logic [IDX_W-1:0]    cur_idx;
    phase_e              cur_phase;
    logic [NUM_COMP-1:0] comp_we;

    pal_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .idx_wr   (idx_wr),
        .col_wr   (col_wr)
    );

    pal_seq #(.IDX_W(IDX_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .col_wr (col_wr),
        .new_idx(bus_wdata[DATA_W-1 -: IDX_W]),
        .idx_q  (cur_idx),
        .phase_q(cur_phase),
        .comp_we(comp_we)
    );

    pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .comp_we(comp_we),
        .w_idx  (cur_idx),
        .w_byte (bus_wdata[DATA_W-1 -: COMP_W]),
        .r_idx  (lkp_idx),
        .r_rgb  (lkp_rgb)
    );

    assign bus_rdata = '0;
endmodule

// File: rtl/pal_dac_loader_chk.sv
module pal_dac_loader_chk
    import pal_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [IDX_W-1:0]  idx_q,
    input phase_e            phase_q
);
    logic wr_any, wr_idx, wr_col;
    assign wr_any = bus_valid && bus_write;
    assign wr_idx = wr_any && (bus_addr[ADDR_W-1:2] == '0);
    assign wr_col = wr_any && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));

    assert_index_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idx |=> (idx_q == $past(bus_wdata[DATA_W-1 -: IDX_W])) && (phase_q == PH_RED));

    assert_phase_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_col && phase_q == PH_RED) |=> (phase_q == PH_GRN) && $stable(idx_q));

    assert_blue_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_col && phase_q == PH_BLU) |=>
            (phase_q == PH_RED) && (idx_q == IDX_W'($past(idx_q) + IDX_W'(1))));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_idx || wr_col) |=> $stable(idx_q) && $stable(phase_q));

    assert_phase_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != 2'd3);
endmodule

bind pal_dac_loader pal_dac_loader_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .idx_q    (cur_idx),
    .phase_q  (cur_phase)
);

// File: tb/pal_dac_loader_test.sv
`timescale 1ns/1ps
module pal_dac_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lkp_idx = '0;
    logic [23:0] lkp_rgb;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit armed = 0;
    string cur_req = "R1";

    // behavioural reference
    logic [23:0] m_mem [256];
    int          m_idx;
    int          m_ph;
    logic [23:0] exp_rgb;

    always #2.5 clk = ~clk;

    pal_dac_loader uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lkp_idx(lkp_idx), .lkp_rgb(lkp_rgb)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_mem[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
            m_idx = 0;
            m_ph = 0;
            exp_rgb = 24'h0;
        end else begin
            exp_rgb = m_mem[lkp_idx];
            if (bus_valid && bus_write) begin
                if (bus_addr[3:2] == 2'd0) begin
                    m_idx = bus_wdata[31:24];
                    m_ph = 0;
                end else if (bus_addr[3:2] == 2'd1) begin
                    case (m_ph)
                        0: m_mem[m_idx][23:16] = bus_wdata[31:24];
                        1: m_mem[m_idx][15:8]  = bus_wdata[31:24];
                        default: m_mem[m_idx][7:0] = bus_wdata[31:24];
                    endcase
                    m_ph = m_ph + 1;
                    if (m_ph == 3) begin
                        m_ph = 0;
                        m_idx = (m_idx + 1) % 256;
                    end
                end
            end
        end
        armed = 1;
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (lkp_rgb !== exp_rgb) begin
                failures++;
                $display("FAIL %s/R9 lookup idx=%0d rgb actual=%h expected=%h", cur_req, lkp_idx, lkp_rgb, exp_rgb);
            end
            checks++;
            if (bus_rdata !== 32'h0) begin
                failures++;
                $display("FAIL R8 rdata actual=%h expected=0", bus_rdata);
            end
        end
    end

    task automatic bus_op(input bit v, input bit w, input logic [3:0] a, input logic [31:0] d);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_op(1'b1, 1'b1, a, d);
    endtask

    task automatic look(input logic [7:0] idx, input logic [23:0] exp, input string tag);
        lkp_idx = idx;
        @(negedge clk);
        checks++;
        if (lkp_rgb !== exp) begin
            failures++;
            $display("FAIL %s entry %0d actual=%h expected=%h", tag, idx, lkp_rgb, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        for (int i = 0; i < 256; i++) begin
            lkp_idx = 8'(i);
            @(negedge clk);
        end
        look(8'd255, 24'hFFFFFF, "R1");
        look(8'd254, 24'h000000, "R1");
        wr(4'h4, 32'h11000000); wr(4'h4, 32'h22000000); wr(4'h4, 32'h33000000);
        look(8'd0, 24'h112233, "R1");

        cur_req = "R3";
        wr(4'h0, 32'h40000000);
        cur_req = "R4";
        wr(4'h4, 32'hA1000000); wr(4'h4, 32'hB2000000); wr(4'h4, 32'hC3000000);
        look(8'h40, 24'hA1B2C3, "R4");

        cur_req = "R10";
        wr(4'h0, 32'h50FFFFFF);
        wr(4'h4, 32'h01ABCDEF); wr(4'h4, 32'h0212345F); wr(4'h4, 32'h03FFFFFF);
        look(8'h50, 24'h010203, "R10");

        cur_req = "R5";
        wr(4'h0, 32'hFF000000);
        for (int k = 0; k < 9; k++) wr(4'h4, 32'((k + 1) * 16) << 24);
        look(8'hFF, 24'h102030, "R5");
        look(8'h00, 24'h405060, "R5");
        look(8'h01, 24'h708090, "R5");

        cur_req = "R6";
        wr(4'h0, 32'h0A000000);
        wr(4'h4, 32'h77000000);
        wr(4'h0, 32'h14000000);
        wr(4'h4, 32'h88000000); wr(4'h4, 32'h99000000); wr(4'h4, 32'hAA000000);
        look(8'h0A, 24'h770000, "R6");
        look(8'h14, 24'h8899AA, "R6");

        cur_req = "R7";
        wr(4'h0, 32'h30000000);
        wr(4'h4, 32'h12000000);
        wr(4'h8, 32'hEE000000);
        wr(4'hC, 32'h05000000);
        bus_op(1'b0, 1'b1, 4'h4, 32'hDD000000);
        bus_op(1'b1, 1'b0, 4'h4, 32'hCC000000);
        bus_op(1'b1, 1'b0, 4'h0, 32'h60000000);
        look(8'h30, 24'h120000, "R7");
        wr(4'h4, 32'h34000000); wr(4'h4, 32'h56000000);
        look(8'h30, 24'h123456, "R7");
        look(8'h31, 24'h000000, "R7");

        cur_req = "R2";
        wr(4'h3, 32'h70000000);
        wr(4'h5, 32'h0F000000); wr(4'h6, 32'h1E000000); wr(4'h7, 32'h2D000000);
        look(8'h70, 24'h0F1E2D, "R2");

        cur_req = "R8";
        for (int k = 0; k < 16; k++) bus_op(1'b1, 1'b0, 4'(k), 32'h0);

        cur_req = "R9";
        wr(4'h0, 32'h21000000);
        lkp_idx = 8'h21;
        wr(4'h4, 32'h5A000000);
        wr(4'h4, 32'h6B000000);
        wr(4'h4, 32'h7C000000);
        @(negedge clk);
        look(8'h21, 24'h5A6B7C, "R9");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule